// File: doc/BRIEF.md
# Phase-Frequency Detector and Charge-Pump Sequencer

This block sits between the two programmable dividers of a frequency synthesizer loop and the analog charge pump. It watches the divided reference clock and the divided feedback clock, finds their rising edges, and keeps a pair of state flops that say which edge came first. Those flops become the pump-up and pump-down controls. The block also applies the loop's mode settings: VCO slope polarity, forced high impedance, low or high pump current, a fastlock boost, and powerdown.

Powerdown has two flavours that depend on the high-impedance setting at the moment the powerdown request is loaded. With high impedance selected, the loop powers down on the load strobe. Otherwise the request waits until the pump is idle, so that no correction pulse is cut short. A lock monitor counts consecutive comparison cycles with narrow correction pulses. While the loop is powered down, the divider-hold output keeps the external counters in their load state.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: A rising edge on the reference input sets the internal up flop at the next clock edge. A rising edge on the feedback input sets the down flop at the next clock edge. A flop that is set stays set until both are set. Everything is zero after reset, and the power state is 0.
- R2: When both flops are set, both clear together at the next clock edge. Any edge that arrives in that same cycle is dropped. Both controls are never high together for more than one cycle.
- R3: With the polarity input at 1 (positive slope), pump_up_o follows the up flop and pump_dn_o follows the down flop. With the polarity input at 0, the two are swapped.
- R4: While the tri-state input is 1, or the loop is powered down, pump_hiz_o is 1 and both pump controls are 0.
- R5: The current code is CUR_LO when low current is selected and 4*CUR_LO when high current is selected (defaults 2 and 8).
- R6: With the fastlock mode input at 1, setting the current input to 1 enters fastlock at the next clock edge. In fastlock, fl_sw_o is 1 (the switch drives low) and the code is 4*CUR_LO. With fastlock mode at 1 and the current input at 0, the code is CUR_LO.
- R7: Leaving fastlock happens only at a clock edge where both flops were clear beforehand. Until then, fl_sw_o and the high code stay in place.
- R8: A load strobe with the powerdown input at 1 and the tri-state input at 1 makes the power state 2 (off) at the next edge.
- R9: A load strobe with the powerdown input at 1 and the tri-state input at 0 enters state 2 directly if the pump is idle. Otherwise it enters state 1 (pending) and moves to 2 at the first edge that sees both flops clear.
- R10: A load strobe with the powerdown input at 0 makes the state 0 at the next edge, whatever the state was. In state 2, div_hold_o is 1, both flops are held clear, and divider edges have no effect on the pump outputs.
- R11: The lock output rises after LOCK_CNT (default 4) consecutive comparison cycles whose one-sided pulse width, in clocks, is below lock_thr_i. It clears at the first comparison whose width reaches the threshold, and on powerdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div_i | input | 1 | Divided reference clock |
| fb_div_i | input | 1 | Divided feedback clock |
| load_i | input | 1 | One-cycle strobe: mode bits were just loaded |
| pol_pos_i | input | 1 | 1 = positive VCO slope, 0 = negative |
| tri_i | input | 1 | 1 = force pump to high impedance |
| cur_hi_i | input | 1 | 1 = high current (fastlock request in fastlock mode) |
| fl_mode_i | input | 1 | 1 = fastlock mode selected |
| pd_i | input | 1 | Powerdown request, acted on at load_i |
| lock_thr_i | input | WID_W | Pulse-width limit for lock, in clocks |
| pump_up_o | output | 1 | Pump source control |
| pump_dn_o | output | 1 | Pump sink control |
| pump_hiz_o | output | 1 | Pump high-impedance enable |
| cur_code_o | output | CUR_W | Pump current scale code |
| fl_sw_o | output | 1 | Open-drain damping-resistor switch, 1 = pull low |
| lock_o | output | 1 | Lock indication |
| pwr_state_o | output | 2 | 0 on, 1 powerdown pending, 2 off |
| div_hold_o | output | 1 | Hold dividers in their load state |

## Verification
Input edges, the fastlock state, the power state and the lock flag all take effect at the first clock edge after the stimulus is driven. The pump controls, the high-impedance enable and the current code also follow the level mode inputs combinationally. Each cycle the bench drives inputs just after the falling edge and advances its cycle model one step after the rising edge. It then compares every output at the next falling edge. Directed sequences first make the pump busy and then look at the pending powerdown and the fastlock exit. This shows the one-edge difference between the synchronous and immediate cases.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
   typedef enum logic [1:0] {
      PWR_ON   = 2'd0,
      PWR_PEND = 2'd1,
      PWR_OFF  = 2'd2
   } pwr_st_e;
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o
);
   logic [SYNC_STAGES:0] chain;
   logic                 last_q;

   assign chain[0] = sig_i;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i+1] <= 1'b0;
         else        chain[i+1] <= chain[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[SYNC_STAGES];
   end

   assign rise_o = chain[SYNC_STAGES] & ~last_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic ref_rise_i,
   input  logic fb_rise_i,
   output logic up_o,
   output logic dn_o
);
   logic up_q, dn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (hold_i || (up_q && dn_q)) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_q | ref_rise_i;
         dn_q <= dn_q | fb_rise_i;
      end
   end

   assign up_o = up_q;
   assign dn_o = dn_q;

   // R2
   pair_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && dn_q) |=> !(up_q && dn_q));

   // R10
   hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (!up_q && !dn_q));

   // R1
   ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_rise_i && !hold_i && !(up_q && dn_q)) |=> up_q);
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
   parameter int unsigned WID_W    = 6,
   parameter int unsigned LOCK_CNT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic             up_i,
   input  logic             dn_i,
   input  logic [WID_W-1:0] thr_i,
   output logic             lock_o
);
   localparam int unsigned GOOD_W = $clog2(LOCK_CNT + 1);
   localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_CNT);

   logic [WID_W-1:0]  wid_q;
   logic [GOOD_W-1:0] good_q, good_nxt;
   logic              lock_q;
   logic              cmp_evt, one_side;

   assign cmp_evt  = up_i && dn_i;
   assign one_side = up_i ^ dn_i;
   assign good_nxt = (good_q == GOOD_MAX) ? good_q : good_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wid_q  <= '0;
         good_q <= '0;
         lock_q <= 1'b0;
      end else if (hold_i) begin
         wid_q  <= '0;
         good_q <= '0;
         lock_q <= 1'b0;
      end else if (cmp_evt) begin
         wid_q <= '0;
         if (wid_q < thr_i) begin
            good_q <= good_nxt;
            lock_q <= (good_nxt == GOOD_MAX);
         end else begin
            good_q <= '0;
            lock_q <= 1'b0;
         end
      end else if (one_side && (wid_q != '1)) begin
         wid_q <= wid_q + 1'b1;
      end
   end

   assign lock_o = lock_q;

   // R11
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(up_i && dn_i));

   // R11
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> !lock_q);
endmodule

// File: rtl/pfd_pwr_seq.sv
module pfd_pwr_seq
   import pfd_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    le_i,
   input  logic    pd_i,
   input  logic    tri_i,
   input  logic    idle_i,
   output pwr_st_e state_o
);
   pwr_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (le_i) begin
         if (!pd_i)                st_d = PWR_ON;
         else if (tri_i || idle_i) st_d = PWR_OFF;
         else                      st_d = PWR_PEND;
      end else if (st_q == PWR_PEND && idle_i) begin
         st_d = PWR_OFF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PWR_ON;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

   // R8
   async_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (le_i && pd_i && tri_i) |=> (st_q == PWR_OFF));

   // R9
   sync_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PWR_PEND && !idle_i && !le_i) |=> (st_q == PWR_PEND));

   // R10
   wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (le_i && !pd_i) |=> (st_q == PWR_ON));
endmodule

// File: rtl/pfd_pump_ctrl.sv
module pfd_pump_ctrl
   import pfd_pkg::*;
#(
   parameter int unsigned CUR_W       = 4,
   parameter int unsigned CUR_LO      = 2,
   parameter int unsigned WID_W       = 6,
   parameter int unsigned LOCK_CNT    = 4,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          FL_ENABLE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_div_i,
   input  logic             fb_div_i,
   input  logic             load_i,
   input  logic             pol_pos_i,
   input  logic             tri_i,
   input  logic             cur_hi_i,
   input  logic             fl_mode_i,
   input  logic             pd_i,
   input  logic [WID_W-1:0] lock_thr_i,
   output logic             pump_up_o,
   output logic             pump_dn_o,
   output logic             pump_hiz_o,
   output logic [CUR_W-1:0] cur_code_o,
   output logic             fl_sw_o,
   output logic             lock_o,
   output logic [1:0]       pwr_state_o,
   output logic             div_hold_o
);
   localparam int unsigned CUR_HI = CUR_LO * 4;
   localparam logic [CUR_W-1:0] CODE_LO = CUR_W'(CUR_LO);
   localparam logic [CUR_W-1:0] CODE_HI = CUR_W'(CUR_HI);

   if (CUR_LO == 0 || CUR_HI >= (1 << CUR_W)) begin : g_bad_cur
      $error("pfd_pump_ctrl: CUR_W too narrow for 4*CUR_LO or CUR_LO is zero");
   end
   if (LOCK_CNT < 1 || WID_W < 2) begin : g_bad_lock
      $error("pfd_pump_ctrl: LOCK_CNT must be >= 1 and WID_W >= 2");
   end

   logic    ref_rise, fb_rise;
   logic    up_q, dn_q;
   logic    hold, idle;
   logic    fl_act, hi_sel, hiz;
   pwr_st_e pst;

   pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(ref_div_i), .rise_o(ref_rise));

   pfd_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(fb_div_i), .rise_o(fb_rise));

   pfd_core u_core (
      .clk(clk), .rst_n(rst_n), .hold_i(hold),
      .ref_rise_i(ref_rise), .fb_rise_i(fb_rise),
      .up_o(up_q), .dn_o(dn_q));

   pfd_lock_det #(.WID_W(WID_W), .LOCK_CNT(LOCK_CNT)) u_lock (
      .clk(clk), .rst_n(rst_n), .hold_i(hold),
      .up_i(up_q), .dn_i(dn_q), .thr_i(lock_thr_i), .lock_o(lock_o));

   pfd_pwr_seq u_pwr (
      .clk(clk), .rst_n(rst_n), .le_i(load_i), .pd_i(pd_i),
      .tri_i(tri_i), .idle_i(idle), .state_o(pst));

   assign hold = (pst == PWR_OFF);
   assign idle = !up_q && !dn_q;

   if (FL_ENABLE) begin : g_fastlock
      logic fl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      fl_q <= 1'b0;
         else if (fl_mode_i && cur_hi_i)  fl_q <= 1'b1;
         else if (idle)                   fl_q <= 1'b0;
      end
      assign fl_act = fl_q;
      assign hi_sel = fl_q | (!fl_mode_i & cur_hi_i);

      // R7
      fl_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(fl_q) |-> $past(idle));

      // R6
      fl_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fl_mode_i && cur_hi_i) |=> (fl_sw_o && cur_code_o == CODE_HI));
   end else begin : g_no_fastlock
      assign fl_act = 1'b0;
      assign hi_sel = cur_hi_i;
   end

   assign cur_code_o = hi_sel ? CODE_HI : CODE_LO;
   assign fl_sw_o    = fl_act;

   assign hiz       = tri_i | hold;
   assign pump_hiz_o = hiz;
   assign pump_up_o = !hiz && (pol_pos_i ? up_q : dn_q);
   assign pump_dn_o = !hiz && (pol_pos_i ? dn_q : up_q);

   assign pwr_state_o = pst;
   assign div_hold_o  = hold;

   // R5
   code_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_code_o == CODE_LO) || (cur_code_o == CODE_HI));

   // R4
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pst == PWR_OFF) |-> (!pump_up_o && !pump_dn_o));
endmodule

// File: tb/sim_pfd_pump_ctrl.sv
module sim_pfd_pump_ctrl;
   localparam int LO = 2;
   localparam int HI = 8;
   localparam int LCNT = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_i = 0, fb_i = 0, le = 0, pol = 1, tri_b = 0, cur_hi = 0, fl_mode = 0, pd = 0;
   logic [5:0] thr = 6'd3;
   logic       pump_up_o, pump_dn_o, pump_hiz_o, fl_sw_o, lock_o, div_hold_o;
   logic [3:0] cur_code_o;
   logic [1:0] pwr_state_o;

   int nchk = 0, nfail = 0, wd = 0;
   int m_refq = 0, m_fbq = 0, m_up = 0, m_dn = 0, m_wid = 0, m_good = 0, m_lock = 0, m_st = 0, m_fl = 0;

   always #4 clk = ~clk;

   pfd_pump_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ref_div_i(ref_i), .fb_div_i(fb_i), .load_i(le),
      .pol_pos_i(pol), .tri_i(tri_b), .cur_hi_i(cur_hi), .fl_mode_i(fl_mode), .pd_i(pd),
      .lock_thr_i(thr), .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o),
      .pump_hiz_o(pump_hiz_o), .cur_code_o(cur_code_o), .fl_sw_o(fl_sw_o),
      .lock_o(lock_o), .pwr_state_o(pwr_state_o), .div_hold_o(div_hold_o));

   task automatic check(input bit ok, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
      end
   endtask

   // cycle model built from the requirements
   task automatic model_step();
      int rr, fr, idle, off, g;
      rr = ref_i && !m_refq;
      fr = fb_i && !m_fbq;
      idle = !m_up && !m_dn;
      off = (m_st == 2);
      m_refq = ref_i;
      m_fbq = fb_i;
      // R11 lock monitor (uses old flop values)
      if (off) begin
         m_wid = 0; m_good = 0; m_lock = 0;
      end else if (m_up && m_dn) begin
         if (m_wid < int'(thr)) begin
            g = (m_good == LCNT) ? m_good : m_good + 1;
            m_good = g;
            m_lock = (g >= LCNT);
         end else begin
            m_good = 0; m_lock = 0;
         end
         m_wid = 0;
      end else if (m_up != m_dn) begin
         if (m_wid < 63) m_wid++;
      end
      // R9 power sequencing
      if (le) begin
         if (!pd) m_st = 0;
         else if (tri_b || idle) m_st = 2;
         else m_st = 1;
      end else if (m_st == 1 && idle) m_st = 2;
      // R7 fastlock
      if (fl_mode && cur_hi) m_fl = 1;
      else if (idle) m_fl = 0;
      // R1/R2 detector flops
      if (off || (m_up && m_dn)) begin
         m_up = 0; m_dn = 0;
      end else begin
         m_up = m_up | rr;
         m_dn = m_dn | fr;
      end
   endtask

   task automatic compare_all();
      int hz, ue, de, ce;
      hz = tri_b || (m_st == 2);
      ue = !hz && (pol ? m_up : m_dn);
      de = !hz && (pol ? m_dn : m_up);
      ce = (m_fl || (!fl_mode && cur_hi)) ? HI : LO;
      check(pump_up_o == ue, "R3 pump_up_o", pump_up_o, ue);
      check(pump_dn_o == de, "R3 pump_dn_o", pump_dn_o, de);
      check(pump_hiz_o == hz, "R4 pump_hiz_o", pump_hiz_o, hz);
      check(int'(cur_code_o) == ce, "R5 cur_code_o", cur_code_o, ce);
      check(fl_sw_o == m_fl, "R6 fl_sw_o", fl_sw_o, m_fl);
      check(lock_o == m_lock, "R11 lock_o", lock_o, m_lock);
      check(int'(pwr_state_o) == m_st, "R9 pwr_state_o", pwr_state_o, m_st);
      check(div_hold_o == (m_st == 2), "R10 div_hold_o", div_hold_o, m_st == 2);
   endtask

   task automatic tick();
      @(posedge clk);
      #1 model_step();
      @(negedge clk);
      compare_all();
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         nfail++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", wd, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(pump_up_o == 0 && pump_dn_o == 0, "R1 reset pump", pump_up_o, 0);
      check(pwr_state_o == 0 && lock_o == 0, "R1 reset state", pwr_state_o, 0);
      rst_n = 1'b1;
      tick(); tick();

      // R1 reference edge sets up
      ref_i = 1; tick();
      check(pump_up_o == 1 && pump_dn_o == 0, "R1 up after ref edge", pump_up_o, 1);
      // R2 both set then clear together
      fb_i = 1; tick();
      check(pump_up_o && pump_dn_o, "R2 both high", pump_dn_o, 1);
      tick();
      check(!pump_up_o && !pump_dn_o, "R2 cleared together", pump_up_o, 0);
      ref_i = 0; fb_i = 0; tick();

      // R3 negative polarity swaps
      pol = 0; ref_i = 1; tick();
      check(pump_dn_o == 1 && pump_up_o == 0, "R3 swapped", pump_dn_o, 1);
      fb_i = 1; tick(); tick();
      ref_i = 0; fb_i = 0; pol = 1; tick();

      // R4 tri-state
      tri_b = 1; ref_i = 1; tick();
      check(pump_hiz_o == 1 && pump_up_o == 0 && pump_dn_o == 0, "R4 hiz quiet", pump_up_o, 0);
      fb_i = 1; tick(); tick();
      tri_b = 0; ref_i = 0; fb_i = 0; tick();

      // R5 current levels
      check(cur_code_o == LO, "R5 low code", cur_code_o, LO);
      cur_hi = 1; tick();
      check(cur_code_o == HI, "R5 high code", cur_code_o, HI);

      // R6 fastlock entry, R7 synchronous exit
      fl_mode = 1; tick();
      check(fl_sw_o == 1 && cur_code_o == HI, "R6 fastlock on", fl_sw_o, 1);
      ref_i = 1; tick();
      cur_hi = 0; tick();
      check(fl_sw_o == 1 && cur_code_o == HI, "R7 held while busy", fl_sw_o, 1);
      fb_i = 1; tick(); tick();
      check(fl_sw_o == 1, "R7 held through clear", fl_sw_o, 1);
      tick();
      check(fl_sw_o == 0 && cur_code_o == LO, "R7 exited when idle", fl_sw_o, 0);
      fl_mode = 0; ref_i = 0; fb_i = 0; tick();

      // R8 immediate powerdown
      tri_b = 1; pd = 1; le = 1; tick();
      le = 0;
      check(pwr_state_o == 2 && div_hold_o == 1, "R8 off at once", pwr_state_o, 2);
      // R10 edges ignored while off, then wake
      tri_b = 0; ref_i = 1; tick();
      check(pump_up_o == 0 && pump_hiz_o == 1, "R10 held off", pump_up_o, 0);
      pd = 0; le = 1; tick();
      le = 0;
      check(pwr_state_o == 0 && pump_up_o == 0, "R10 awake no stale edge", pwr_state_o, 0);
      ref_i = 0; tick();

      // R9 synchronous powerdown waits for idle
      ref_i = 1; tick();
      pd = 1; le = 1; tick();
      le = 0;
      check(pwr_state_o == 1, "R9 pending", pwr_state_o, 1);
      tick();
      check(pwr_state_o == 1, "R9 still pending", pwr_state_o, 1);
      fb_i = 1; tick(); tick();
      check(pwr_state_o == 1, "R9 pending through clear", pwr_state_o, 1);
      tick();
      check(pwr_state_o == 2, "R9 off after idle", pwr_state_o, 2);
      pd = 0; le = 1; tick();
      le = 0; ref_i = 0; fb_i = 0; tick();

      // R11 lock acquire and loss
      thr = 6'd2;
      for (int c = 0; c < 36; c++) begin
         ref_i = (c % 6) < 3; fb_i = (c % 6) < 3; tick();
      end
      check(lock_o == 1, "R11 locked", lock_o, 1);
      for (int c = 0; c < 18; c++) begin
         ref_i = (c % 6) < 3; fb_i = ((c + 3) % 6) < 3; tick();
      end
      check(lock_o == 0, "R11 lock lost", lock_o, 0);

      // constrained random segments
      for (int seg = 0; seg < 40; seg++) begin
         int rp, fp, off;
         rp = 6 + int'($urandom % 10);
         fp = ($urandom % 4 == 0) ? rp + 1 : rp;
         off = (seg % 3 == 0) ? 0 : int'($urandom % rp);
         pol = $urandom % 2; cur_hi = $urandom % 2; fl_mode = $urandom % 2;
         tri_b = ($urandom % 8 == 0);
         thr = 6'(1 + $urandom % 4);
         pd = ($urandom % 6 == 0);
         le = 1;
         for (int c = 0; c < 60; c++) begin
            ref_i = (c % rp) < rp / 2;
            fb_i = ((c + off) % fp) < fp / 2;
            tick();
            le = 0;
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule